// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns single read or write requests from an internal requester into cycles on an external asynchronous memory bus. The requester presents an address, write data and a direction flag with a valid signal. The block answers with a one-clock acknowledge once the external cycle ends. For a read, the returned data is captured from the bus on that same clock edge.

Each external cycle lasts at least a programmed number of wait states. When that number is non-zero, an active-low transfer-acknowledge input must also be seen before the cycle may end, so a slow device can stretch the cycle as long as it needs. The acknowledge can be used directly, or passed through a two-flop synchronizer when it arrives from another clock domain.

Four address windows, each a base and a mask, drive four attribute (select) lines. These lines either carry a one-hot choice of the lowest-numbered matching window, or carry the raw match vector for decoding outside the block. All external outputs are enabled only while an input says the block owns the bus.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: After reset, reqAck is 0, extRdN and extWrN are both 1, and extSel is all zeros.
- R2: In a read cycle only extRdN is low, and in a write cycle only extWrN is low. The strobe stays low for cfgWaitStates+1 clocks at minimum.
- R3: With cfgWaitStates of 1 or more, the cycle also waits for extAckN. In direct mode the strobe stays low for max(W+1, d+2) clocks, where W is the wait count and d is the number of strobe-low clocks before extAckN goes low. So the cycle ends on the clock edge after the one that first samples extAckN low.
- R4: With cfgWaitStates equal to 0, extAckN is ignored and the strobe is low for exactly one clock.
- R5: With cfgAckAsync=1, extAckN passes through a two-flop synchronizer, so the strobe stays low for max(W+1, d+4) clocks.
- R6: reqAck is high for exactly one clock at the end of each cycle. For a read, rspRdata then holds the value of extDataIn sampled on that same edge.
- R7: extAddr changes only when a cycle starts, and it keeps the last address while the bus is idle.
- R8: With cfgEncodedSel=0, extSel is driven during the cycle as a one-hot vector for the lowest-numbered window whose (addr & mask) equals (base & mask). It is all zeros when no window matches. Window i uses bits [i*18 +: 18] of the base and mask inputs, and bit i of extSel.
- R9: With cfgEncodedSel=1, extSel carries every matching window's bit at once.
- R10: While busOwned is 0, no cycle starts and every output enable (extAddrOe, extDataOe, extStrobeOe, extSelOe) is 0. Acknowledge is ignored while no cycle is running.
- R11: extDataOe is 1, with extDataOut equal to the write data, only during the strobe of a write cycle. It is 0 during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Requester has a transfer pending |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Transfer address |
| reqWdata | input | 24 | Write data |
| reqAck | output | 1 | One-clock completion pulse |
| rspRdata | output | 24 | Captured read data |
| cfgWaitStates | input | 4 | Minimum wait states |
| cfgAckAsync | input | 1 | 1 = synchronize extAckN first |
| cfgEncodedSel | input | 1 | 1 = raw match vector on extSel |
| cfgRegionBase | input | 72 | Four window bases |
| cfgRegionMask | input | 72 | Four window masks (1 = bit compared) |
| busOwned | input | 1 | Block currently owns the external bus |
| extAckN | input | 1 | Active-low transfer acknowledge |
| extDataIn | input | 24 | Bus data in |
| extAddr | output | 18 | Bus address |
| extAddrOe | output | 1 | Address output enable |
| extDataOut | output | 24 | Bus data out |
| extDataOe | output | 1 | Data output enable |
| extRdN | output | 1 | Active-low read strobe |
| extWrN | output | 1 | Active-low write strobe |
| extStrobeOe | output | 1 | Strobe output enable |
| extSel | output | 4 | Attribute/select lines |
| extSelOe | output | 1 | Select output enable |

## Verification
A cycle starts on the first edge after a valid request. The strobe and select lines change on that edge. The acknowledge pulse and captured read data appear W+1 edges later when no stretching applies. With stretching they appear d+2 edges later, or d+4 in synchronized mode, counted from the start. The bench drives inputs and reads outputs only at falling edges. It counts the strobe-low falling edges from the first one after the start edge up to the falling edge that shows reqAck, and compares that count with the length computed from the rule above. It checks the pulse width one falling edge later.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  typedef enum logic {ST_IDLE, ST_ACCESS} xbc_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;     // cycle begins on this edge
    logic finish;    // cycle ends on this edge
    logic inAccess;  // strobe phase active
  } xbc_strobe_t;
endpackage

// File: rtl/xbc_ctrl.sv
module xbc_ctrl
  import xbc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              busOwned,
  input  logic [WAIT_W-1:0] cfgWaitStates,
  input  logic              cfgAckAsync,
  input  logic              extAckN,
  output xbc_strobe_t       strobe,
  output logic              reqAck
);
  localparam logic [WAIT_W:0] ACC_MAX = '1;

  xbc_state_e        state;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLat;
  logic              ackLat;
  logic              ackSync1, ackSync2;
  logic              ackUse;
  logic [WAIT_W:0]   accCycles;

  // two-flop synchronizer, always running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSync1 <= 1'b0;
      ackSync2 <= 1'b0;
    end else begin
      ackSync1 <= ~extAckN;
      ackSync2 <= ackSync1;
    end
  end

  always_comb begin
    ackUse = (cfgAckAsync ? ackSync2 : ~extAckN) && busOwned;
    strobe.inAccess = (state == ST_ACCESS);
    strobe.start  = (state == ST_IDLE) && reqValid && busOwned && !reqAck;
    strobe.finish = (state == ST_ACCESS) && (waitCnt == '0) &&
                    ((waitLat == '0) || ackLat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      waitLat   <= '0;
      ackLat    <= 1'b0;
      reqAck    <= 1'b0;
      accCycles <= '0;
    end else begin
      reqAck <= strobe.finish;
      if (strobe.start) begin
        state     <= ST_ACCESS;
        waitCnt   <= cfgWaitStates;
        waitLat   <= cfgWaitStates;
        ackLat    <= 1'b0;
        accCycles <= '0;
      end else if (strobe.finish) begin
        state <= ST_IDLE;
      end else if (state == ST_ACCESS) begin
        if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
        ackLat <= ackLat | ackUse;
        if (accCycles != ACC_MAX) accCycles <= accCycles + 1'b1;
      end
    end
  end

  // R2: a cycle never ends before its programmed minimum
  a_r2_min_length: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> (accCycles >= {1'b0, waitLat}));

  // R4: zero wait states gives a single-clock strobe
  a_r4_zero_wait_single: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && waitLat == '0) |=> (state == ST_IDLE));

  // R6: completion pulse lasts one clock
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R10: no cycle starts without bus ownership
  a_r10_no_start_unowned: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !busOwned) |=> (state == ST_IDLE));
endmodule

// File: rtl/xbc_datapath.sv
module xbc_datapath
  import xbc_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 24,
  parameter int NUM_REGIONS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xbc_strobe_t                   strobe,
  input  logic                          busOwned,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic                          cfgEncodedSel,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfgRegionBase,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfgRegionMask,
  input  logic [DATA_W-1:0]             extDataIn,
  output logic [DATA_W-1:0]             rspRdata,
  output logic [ADDR_W-1:0]             extAddr,
  output logic                          extAddrOe,
  output logic [DATA_W-1:0]             extDataOut,
  output logic                          extDataOe,
  output logic                          extRdN,
  output logic                          extWrN,
  output logic                          extStrobeOe,
  output logic [NUM_REGIONS-1:0]        extSel,
  output logic                          extSelOe
);
  logic [NUM_REGIONS-1:0] matchVec;
  logic [NUM_REGIONS-1:0] firstMatch;
  logic [NUM_REGIONS-1:0] selNext;
  logic [ADDR_W-1:0]      addrReg;
  logic [DATA_W-1:0]      wdataReg;
  logic                   writeReg;
  logic                   encReg;
  logic [NUM_REGIONS-1:0] selReg;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [ADDR_W-1:0] rBase, rMask;
    assign rBase = cfgRegionBase[i*ADDR_W +: ADDR_W];
    assign rMask = cfgRegionMask[i*ADDR_W +: ADDR_W];
    assign matchVec[i] = ((reqAddr & rMask) == (rBase & rMask));
  end

  always_comb begin
    firstMatch = matchVec & (~matchVec + NUM_REGIONS'(1));
    selNext    = cfgEncodedSel ? matchVec : firstMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      writeReg <= 1'b0;
      encReg   <= 1'b0;
      selReg   <= '0;
      rspRdata <= '0;
    end else begin
      if (strobe.start) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        writeReg <= reqWrite;
        encReg   <= cfgEncodedSel;
        selReg   <= selNext;
      end else if (strobe.finish) begin
        selReg <= '0;
        if (!writeReg) rspRdata <= extDataIn;
      end
    end
  end

  always_comb begin
    extAddr     = addrReg;
    extAddrOe   = busOwned;
    extDataOut  = wdataReg;
    extDataOe   = busOwned && strobe.inAccess && writeReg;
    extRdN      = !(strobe.inAccess && !writeReg);
    extWrN      = !(strobe.inAccess && writeReg);
    extStrobeOe = busOwned;
    extSel      = selReg;
    extSelOe    = busOwned;
  end

  // R2: never both strobes at once
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!extRdN && !extWrN));

  // R7: address moves only at cycle start
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.start |=> $stable(extAddr));

  // R8: priority mode drives at most one select
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    !encReg |-> $onehot0(extSel));

  // R11: data driven only alongside the write strobe
  a_r11_data_with_write: assert property (@(posedge clk) disable iff (!rstN)
    extDataOe |-> (!extWrN && busOwned));
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbc_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 24,
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  output logic                          reqAck,
  output logic [DATA_W-1:0]             rspRdata,
  input  logic [WAIT_W-1:0]             cfgWaitStates,
  input  logic                          cfgAckAsync,
  input  logic                          cfgEncodedSel,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfgRegionBase,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfgRegionMask,
  input  logic                          busOwned,
  input  logic                          extAckN,
  input  logic [DATA_W-1:0]             extDataIn,
  output logic [ADDR_W-1:0]             extAddr,
  output logic                          extAddrOe,
  output logic [DATA_W-1:0]             extDataOut,
  output logic                          extDataOe,
  output logic                          extRdN,
  output logic                          extWrN,
  output logic                          extStrobeOe,
  output logic [NUM_REGIONS-1:0]        extSel,
  output logic                          extSelOe
);
  xbc_strobe_t strobe;

  xbc_ctrl #(.WAIT_W(WAIT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busOwned(busOwned),
    .cfgWaitStates(cfgWaitStates), .cfgAckAsync(cfgAckAsync),
    .extAckN(extAckN), .strobe(strobe), .reqAck(reqAck)
  );

  xbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busOwned(busOwned),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgEncodedSel(cfgEncodedSel), .cfgRegionBase(cfgRegionBase),
    .cfgRegionMask(cfgRegionMask), .extDataIn(extDataIn), .rspRdata(rspRdata),
    .extAddr(extAddr), .extAddrOe(extAddrOe), .extDataOut(extDataOut),
    .extDataOe(extDataOe), .extRdN(extRdN), .extWrN(extWrN),
    .extStrobeOe(extStrobeOe), .extSel(extSel), .extSelOe(extSelOe)
  );
endmodule

// File: tb/test_xbus_cycle_ctrl.sv
module test_xbus_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [23:0] reqWdata = '0;
  logic        reqAck;
  logic [23:0] rspRdata;
  logic [3:0]  cfgWaitStates = '0;
  logic        cfgAckAsync = 1'b0, cfgEncodedSel = 1'b0;
  logic [71:0] cfgRegionBase, cfgRegionMask;
  logic        busOwned = 1'b1, extAckN = 1'b1;
  logic [23:0] extDataIn = '0;
  logic [17:0] extAddr;
  logic        extAddrOe, extDataOe, extRdN, extWrN, extStrobeOe, extSelOe;
  logic [23:0] extDataOut;
  logic [3:0]  extSel;

  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // window 0: top bits 00; 1: top bits 01; 2: below 0x1000; 3: 0x3F000 page
  assign cfgRegionBase = {18'h3F000, 18'h00000, 18'h10000, 18'h00000};
  assign cfgRegionMask = {18'h3F000, 18'h3F000, 18'h30000, 18'h30000};

  xbus_cycle_ctrl i_xbus_cycle_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .cfgWaitStates(cfgWaitStates), .cfgAckAsync(cfgAckAsync),
    .cfgEncodedSel(cfgEncodedSel), .cfgRegionBase(cfgRegionBase),
    .cfgRegionMask(cfgRegionMask), .busOwned(busOwned), .extAckN(extAckN),
    .extDataIn(extDataIn), .extAddr(extAddr), .extAddrOe(extAddrOe),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .extRdN(extRdN),
    .extWrN(extWrN), .extStrobeOe(extStrobeOe), .extSel(extSel), .extSelOe(extSelOe)
  );

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [23:0] wdata;
    logic [23:0] bdata;
    logic [3:0]  ws;
    logic [7:0]  ackDly;   // 255 = never acknowledged
    logic        async;
    logic        enc;
    logic [3:0]  sel;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 18'h00100, 24'h000000, 24'hA5A5A5, 4'd0, 8'd255, 1'b0, 1'b0, 4'b0001},
    '{1'b1, 18'h12345, 24'h123456, 24'h000000, 4'd0, 8'd0,   1'b0, 1'b0, 4'b0010},
    '{1'b0, 18'h3F800, 24'h000000, 24'h5A5A5A, 4'd3, 8'd0,   1'b0, 1'b0, 4'b1000},
    '{1'b0, 18'h0A000, 24'h000000, 24'hC0FFEE, 4'd1, 8'd5,   1'b0, 1'b0, 4'b0001},
    '{1'b1, 18'h00100, 24'hBEEF01, 24'h000000, 4'd2, 8'd1,   1'b0, 1'b1, 4'b0101},
    '{1'b0, 18'h25000, 24'h000000, 24'h777777, 4'd2, 8'd0,   1'b1, 1'b0, 4'b0000},
    '{1'b1, 18'h3F800, 24'hFACE99, 24'h000000, 4'd1, 8'd6,   1'b1, 1'b1, 4'b1000},
    '{1'b0, 18'h00100, 24'h000000, 24'h314159, 4'd5, 8'd0,   1'b1, 1'b1, 4'b0101}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expLen(input int ws, input int d, input bit async);
    int lat;
    if (ws == 0) return 1;
    lat = async ? 4 : 2;
    return (ws + 1 > d + lat) ? ws + 1 : d + lat;
  endfunction

  task automatic doTxn(input vec_t v);
    int len = 0;
    bit gotAck = 0;
    int expL;
    expL = expLen(int'(v.ws), int'(v.ackDly), v.async);
    reqWrite = v.wr; reqAddr = v.addr; reqWdata = v.wdata; extDataIn = v.bdata;
    cfgWaitStates = v.ws; cfgAckAsync = v.async; cfgEncodedSel = v.enc;
    reqValid = 1'b1; extAckN = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (reqAck) begin gotAck = 1; break; end
      if (!(extRdN && extWrN)) len++;
      if (k == 0) begin
        check(extRdN == v.wr && extWrN == !v.wr, "R2 strobe kind", {extRdN, extWrN}, {v.wr, !v.wr});
        check(extSel == v.sel, v.enc ? "R9 encoded select" : "R8 priority select", extSel, v.sel);
        check(extAddr == v.addr, "R7 address driven", extAddr, v.addr);
        if (v.wr)
          check(extDataOe && extDataOut == v.wdata, "R11 write data", extDataOut, v.wdata);
        else
          check(!extDataOe, "R11 no drive on read", extDataOe, 0);
      end
      if (k >= int'(v.ackDly)) extAckN = 1'b0;
    end
    check(gotAck, "R6 ack arrives", gotAck, 1);
    check(len == expL,
          (v.ws == 0) ? "R4 zero-wait length" : (v.async ? "R5 sync ack length" : "R3 stretch length"),
          len, expL);
    check(extRdN && extWrN && extSel == 4'b0, "R2 strobes released", {extRdN, extWrN, extSel}, 6'b110000);
    if (!v.wr) check(rspRdata == v.bdata, "R6 read data", rspRdata, v.bdata);
    reqValid = 1'b0; extAckN = 1'b1;
    @(negedge clk);
    check(!reqAck, "R6 one-clock ack", reqAck, 0);
    repeat (4) @(negedge clk);
    check(extAddr == v.addr, "R7 address held idle", extAddr, v.addr);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!reqAck && extRdN && extWrN && extSel == 4'b0, "R1 reset state",
          {reqAck, extRdN, extWrN, extSel}, 7'b0110000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) doTxn(VECS[i]);

    // R10: not owner, nothing starts and enables are low
    busOwned = 1'b0;
    reqWrite = 1'b1; reqAddr = 18'h01234; reqWdata = 24'h0F0F0F;
    cfgWaitStates = 4'd0; cfgAckAsync = 1'b0; cfgEncodedSel = 1'b0;
    reqValid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!reqAck && extWrN && !extAddrOe && !extDataOe && !extStrobeOe && !extSelOe,
            "R10 unowned idle",
            {reqAck, extWrN, extAddrOe, extDataOe, extStrobeOe, extSelOe}, 6'b010000);
    end
    busOwned = 1'b1;
    @(negedge clk);
    check(!extWrN && extAddrOe && extDataOe, "R10 starts once owned",
          {extWrN, extAddrOe, extDataOe}, 3'b011);
    @(negedge clk);
    check(reqAck, "R10 completes", reqAck, 1);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);

    // R10: acknowledge held while idle must not shorten the next cycle
    extAckN = 1'b0;
    repeat (5) @(negedge clk);
    check(!reqAck && extRdN, "R10 idle ack ignored", {reqAck, extRdN}, 2'b01);
    extAckN = 1'b1;
    @(negedge clk);
    doTxn(VECS[3]);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule